// File: doc/BRIEF.md
# Timed Event Action Scheduler

This block sits in a timing receiver and fires actions at absolute instants. A master broadcasts messages to every receiver. Each message names a destination node, an action code and the absolute time at which that action must happen. The block keeps only the messages meant for its own node and parks them in a small table of pending events. On every clock it checks each parked event against the local time value. That value counts 8 ns ticks and comes from the distributed clock. When an event falls due, the block raises the matching action strobe on its own, with no further message from the master.

Trigger timing depends only on the local time value and the stored timestamp, so the network delay has no effect on when an action fires. A message whose time has already passed is reported. A configuration input selects whether such a message is dropped or fired at once. A message that finds the table full is reported and discarded.

Top module: `evt_sched`

## Requirements
- R1: During synchronous reset, `act_strobe`, `late_flag`, `ovf_flag` and `msg_ready` are all 0. From the first clock edge after reset is released, `msg_ready` stays at 1.
- R2: An accepted message whose `msg_node` differs from `own_node` is ignored. It raises no flag, no strobe, and takes no table entry.
- R3: A message for this node with `msg_time` >= `utc_now` is stored. Bit `msg_act` of `act_strobe` (one-hot, bit index = action code) is 1 in the cycle after the first cycle in which `utc_now` >= the stored time.
- R4: Due detection uses `utc_now` >= stored time. An event whose exact time is skipped by a jump in `utc_now` still fires in the cycle after the jump is seen.
- R5: All entries that fall due in the same cycle raise their strobe bits together in one cycle. Entries with equal action codes merge into one bit.
- R6: Each strobe lasts one clock, and the entry that fired is freed at the same edge, so it never fires twice.
- R7: A message for this node with `msg_time` < `utc_now` sets `late_flag` high for exactly the next cycle. It is never stored.
- R8: For such a late message, `late_fire_en`=1 sets its action bit in `act_strobe` in the next cycle. With `late_fire_en`=0 the message is dropped and produces no strobe.
- R9: A storable message that arrives while all entries are occupied sets `ovf_flag` for the next cycle and is dropped. An entry that falls due in that same cycle still counts as occupied.
- R10: A message whose `msg_time` equals `utc_now` on arrival is not late. It is stored and its strobe appears two cycles after acceptance.
- R11: The table holds DEPTH (default 8) pending events at once, and all of them fire correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_node | input | NODE_W | Address of this receiver |
| late_fire_en | input | 1 | 1: fire late messages at once; 0: drop them |
| msg_valid | input | 1 | Message present |
| msg_ready | output | 1 | Block accepts messages |
| msg_node | input | NODE_W | Destination node of the message |
| msg_act | input | ACT_W | Action code |
| msg_time | input | TIME_W | Absolute execution time in 8 ns ticks |
| utc_now | input | TIME_W | Local time in 8 ns ticks |
| act_strobe | output | 2**ACT_W | One-hot-per-code action strobes |
| late_flag | output | 1 | Pulse: a late message arrived |
| ovf_flag | output | 1 | Pulse: a message was dropped because the table was full |

## Verification
Some rules hold on every cycle and the assertions check them there:
- each late or overflow pulse traces back to the message that caused it;
- foreign messages stay silent;
- a fired entry is always freed;
- a disabled late message never strobes.

Other behaviour needs a scenario to show it, so the bench's cycle-accurate model covers it:
- the exact cycle in which a strobe appears;
- firing across a time jump;
- simultaneous firing of a full table;
- the equal-time boundary;
- the overflow that arises while an entry is being freed.

// File: rtl/evt_pkg.sv
package evt_pkg;
  // How an incoming message is to be handled
  typedef enum logic [1:0] {
    MSG_NONE  = 2'd0,
    MSG_STORE = 2'd1,
    MSG_LATE  = 2'd2
  } msg_kind_e;
endpackage

// File: rtl/evt_filter.sv
module evt_filter
  import evt_pkg::*;
#(
  parameter int NODE_W = 8,
  parameter int TIME_W = 48
) (
  input  logic              msg_take,
  input  logic [NODE_W-1:0] msg_node,
  input  logic [TIME_W-1:0] msg_time,
  input  logic [NODE_W-1:0] own_node,
  input  logic [TIME_W-1:0] utc_now,
  output msg_kind_e         kind
);
  always_comb begin
    kind = MSG_NONE;
    if (msg_take && (msg_node == own_node)) begin
      if (msg_time < utc_now) kind = MSG_LATE;
      else                    kind = MSG_STORE;
    end
  end
endmodule

// File: rtl/evt_table.sv
module evt_table #(
  parameter int DEPTH  = 8,
  parameter int TIME_W = 48,
  parameter int ACT_W  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [TIME_W-1:0]      wr_time,
  input  logic [ACT_W-1:0]       wr_act,
  input  logic [TIME_W-1:0]      utc_now,
  output logic                   full,
  output logic [DEPTH-1:0]       valid_vec,
  output logic [DEPTH-1:0]       due_vec,
  output logic [DEPTH*ACT_W-1:0] due_act
);
  logic [DEPTH-1:0]  valid_q;
  logic [TIME_W-1:0] time_q [DEPTH];
  logic [ACT_W-1:0]  act_q  [DEPTH];
  logic [DEPTH-1:0]  wr_sel;
  logic              found;

  // lowest free slot, one-hot
  always_comb begin
    wr_sel = '0;
    found  = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_q[i] && !found) begin
        wr_sel[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign due_vec[g] = valid_q[g] && (utc_now >= time_q[g]);
    assign due_act[g*ACT_W +: ACT_W] = act_q[g];

    // payload needs no reset, guarded by valid_q
    always_ff @(posedge clk) begin
      if (wr_en && wr_sel[g]) begin
        time_q[g] <= wr_time;
        act_q[g]  <= wr_act;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && wr_sel[i])  valid_q[i] <= 1'b1;
        else if (due_vec[i])     valid_q[i] <= 1'b0;
      end
    end
  end

  assign full      = &valid_q;
  assign valid_vec = valid_q;
endmodule

// File: rtl/evt_strobe_enc.sv
module evt_strobe_enc #(
  parameter int DEPTH   = 8,
  parameter int ACT_W   = 4,
  parameter int NUM_ACT = 16
) (
  input  logic [DEPTH-1:0]       due_vec,
  input  logic [DEPTH*ACT_W-1:0] due_act,
  input  logic                   late_fire,
  input  logic [ACT_W-1:0]       late_act,
  output logic [NUM_ACT-1:0]     strobe_nxt
);
  always_comb begin
    strobe_nxt = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (due_vec[i]) strobe_nxt[due_act[i*ACT_W +: ACT_W]] = 1'b1;
    end
    if (late_fire) strobe_nxt[late_act] = 1'b1;
  end
endmodule

// File: rtl/evt_sched.sv
module evt_sched
  import evt_pkg::*;
#(
  parameter int NODE_W = 8,
  parameter int ACT_W  = 4,
  parameter int TIME_W = 48,
  parameter int DEPTH  = 8,
  localparam int NUM_ACT = 1 << ACT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NODE_W-1:0]  own_node,
  input  logic               late_fire_en,
  input  logic               msg_valid,
  output logic               msg_ready,
  input  logic [NODE_W-1:0]  msg_node,
  input  logic [ACT_W-1:0]   msg_act,
  input  logic [TIME_W-1:0]  msg_time,
  input  logic [TIME_W-1:0]  utc_now,
  output logic [NUM_ACT-1:0] act_strobe,
  output logic               late_flag,
  output logic               ovf_flag
);
  msg_kind_e              kind;
  logic                   tab_full;
  logic [DEPTH-1:0]       tab_valid;
  logic [DEPTH-1:0]       tab_due;
  logic [DEPTH*ACT_W-1:0] tab_act;
  logic [NUM_ACT-1:0]     strobe_nxt;
  logic                   store_en;
  logic                   late_fire;

  evt_filter #(.NODE_W(NODE_W), .TIME_W(TIME_W)) u_filt (
    .msg_take (msg_valid && msg_ready),
    .msg_node (msg_node),
    .msg_time (msg_time),
    .own_node (own_node),
    .utc_now  (utc_now),
    .kind     (kind)
  );

  assign store_en  = (kind == MSG_STORE) && !tab_full;
  assign late_fire = (kind == MSG_LATE) && late_fire_en;

  evt_table #(.DEPTH(DEPTH), .TIME_W(TIME_W), .ACT_W(ACT_W)) u_tab (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (store_en),
    .wr_time   (msg_time),
    .wr_act    (msg_act),
    .utc_now   (utc_now),
    .full      (tab_full),
    .valid_vec (tab_valid),
    .due_vec   (tab_due),
    .due_act   (tab_act)
  );

  evt_strobe_enc #(.DEPTH(DEPTH), .ACT_W(ACT_W), .NUM_ACT(NUM_ACT)) u_enc (
    .due_vec    (tab_due),
    .due_act    (tab_act),
    .late_fire  (late_fire),
    .late_act   (msg_act),
    .strobe_nxt (strobe_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_strobe <= '0;
      late_flag  <= 1'b0;
      ovf_flag   <= 1'b0;
      msg_ready  <= 1'b0;
    end else begin
      act_strobe <= strobe_nxt;
      late_flag  <= (kind == MSG_LATE);
      ovf_flag   <= (kind == MSG_STORE) && tab_full;
      msg_ready  <= 1'b1;
    end
  end
endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk #(
  parameter int NODE_W  = 8,
  parameter int ACT_W   = 4,
  parameter int TIME_W  = 48,
  parameter int DEPTH   = 8,
  parameter int NUM_ACT = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NODE_W-1:0]  own_node,
  input logic               late_fire_en,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [NODE_W-1:0]  msg_node,
  input logic [TIME_W-1:0]  msg_time,
  input logic [TIME_W-1:0]  utc_now,
  input logic [NUM_ACT-1:0] act_strobe,
  input logic               late_flag,
  input logic               ovf_flag,
  input logic [DEPTH-1:0]   tab_valid,
  input logic [DEPTH-1:0]   tab_due
);
  logic mine, is_late;
  assign mine    = msg_valid && msg_ready && (msg_node == own_node);
  assign is_late = mine && (msg_time < utc_now);

  // R2
  p_foreign_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_node != own_node) |=> (!late_flag && !ovf_flag));
  // R3
  p_strobe_cause_r3: assert property (@(posedge clk) disable iff (rst)
    (act_strobe != '0) |-> $past((tab_due != '0) || (is_late && late_fire_en)));
  // R6
  p_fired_freed_r6: assert property (@(posedge clk) disable iff (rst)
    (tab_due != '0) |=> ((tab_valid & $past(tab_due)) == '0));
  // R7
  p_late_cause_r7: assert property (@(posedge clk) disable iff (rst)
    late_flag |-> $past(is_late));
  // R7
  p_late_not_ovf_r7: assert property (@(posedge clk) disable iff (rst)
    !(late_flag && ovf_flag));
  // R8
  p_late_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (is_late && !late_fire_en && tab_due == '0) |=> (act_strobe == '0));
  // R9
  p_ovf_full_r9: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> $past((&tab_valid) && mine && !(msg_time < utc_now)));
endmodule

bind evt_sched evt_sched_chk #(
  .NODE_W(NODE_W), .ACT_W(ACT_W), .TIME_W(TIME_W), .DEPTH(DEPTH), .NUM_ACT(NUM_ACT)
) u_chk (
  .clk(clk), .rst(rst), .own_node(own_node), .late_fire_en(late_fire_en),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_node(msg_node),
  .msg_time(msg_time), .utc_now(utc_now), .act_strobe(act_strobe),
  .late_flag(late_flag), .ovf_flag(ovf_flag), .tab_valid(tab_valid), .tab_due(tab_due)
);

// File: tb/sim_evt_sched.sv
module sim_evt_sched;
  localparam int NODE_W  = 8;
  localparam int ACT_W   = 4;
  localparam int TIME_W  = 48;
  localparam int DEPTH   = 8;
  localparam int NUM_ACT = 1 << ACT_W;
  localparam logic [NODE_W-1:0] ME = 8'h2A;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst = 1'b1;
  logic [NODE_W-1:0]  own_node = ME;
  logic               late_fire_en = 1'b0;
  logic               msg_valid = 1'b0;
  logic               msg_ready;
  logic [NODE_W-1:0]  msg_node = '0;
  logic [ACT_W-1:0]   msg_act = '0;
  logic [TIME_W-1:0]  msg_time = '0;
  logic [TIME_W-1:0]  utc_now = 48'd1000;
  logic [NUM_ACT-1:0] act_strobe;
  logic               late_flag, ovf_flag;

  evt_sched #(.NODE_W(NODE_W), .ACT_W(ACT_W), .TIME_W(TIME_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .own_node(own_node), .late_fire_en(late_fire_en),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_node(msg_node),
    .msg_act(msg_act), .msg_time(msg_time), .utc_now(utc_now),
    .act_strobe(act_strobe), .late_flag(late_flag), .ovf_flag(ovf_flag)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // behavioural reference: list of pending events
  longint unsigned pq_time[$];
  int              pq_act[$];
  logic [NUM_ACT-1:0] e_strobe = '0;
  logic e_late = 1'b0, e_ovf = 1'b0;

  task automatic model_step();
    bit was_full;
    was_full = (pq_time.size() == DEPTH);
    e_strobe = '0; e_late = 1'b0; e_ovf = 1'b0;
    for (int i = pq_time.size() - 1; i >= 0; i--) begin
      if (pq_time[i] <= longint'(utc_now)) begin
        e_strobe[pq_act[i]] = 1'b1;
        pq_time.delete(i);
        pq_act.delete(i);
      end
    end
    if (msg_valid && msg_ready && msg_node == own_node) begin
      if (msg_time < utc_now) begin
        e_late = 1'b1;
        if (late_fire_en) e_strobe[msg_act] = 1'b1;
      end else if (was_full) begin
        e_ovf = 1'b1;
      end else begin
        pq_time.push_back(longint'(msg_time));
        pq_act.push_back(int'(msg_act));
      end
    end
  endtask

  task automatic compare(string tag);
    vectors++;
    if (act_strobe !== e_strobe) begin
      miscompares++;
      $display("FAIL %s act_strobe actual=%h expected=%h", tag, act_strobe, e_strobe);
    end
    if (late_flag !== e_late) begin
      miscompares++;
      $display("FAIL %s late_flag actual=%b expected=%b", tag, late_flag, e_late);
    end
    if (ovf_flag !== e_ovf) begin
      miscompares++;
      $display("FAIL %s ovf_flag actual=%b expected=%b", tag, ovf_flag, e_ovf);
    end
    if (msg_ready !== 1'b1) begin
      miscompares++;
      $display("FAIL R1 msg_ready actual=%b expected=1", msg_ready);
    end
  endtask

  // one clock: model at the edge, compare mid-cycle, then advance time
  task automatic step(string tag);
    @(posedge clk);
    #1 model_step();
    @(negedge clk);
    compare(tag);
    msg_valid = 1'b0;
    utc_now   = utc_now + 1;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic send(string tag, logic [NODE_W-1:0] nd, logic [ACT_W-1:0] ac,
                      logic [TIME_W-1:0] t);
    msg_valid = 1'b1; msg_node = nd; msg_act = ac; msg_time = t;
    step(tag);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    vectors++;
    if (act_strobe !== '0 || late_flag !== 1'b0 || ovf_flag !== 1'b0 || msg_ready !== 1'b0) begin
      miscompares++;
      $display("FAIL R1 reset outputs actual=%h/%b/%b/%b expected=0/0/0/0",
               act_strobe, late_flag, ovf_flag, msg_ready);
    end
    rst = 1'b0;
    idle("R1", 2);

    // R3: single future event
    send("R3", ME, 4'd3, utc_now + 5);
    idle("R3", 8);

    // R2: foreign node ignored
    send("R2", 8'h11, 4'd6, utc_now + 3);
    send("R2", 8'h11, 4'd7, utc_now - 3);
    idle("R2", 6);

    // R5: same due time, distinct and equal codes
    send("R5", ME, 4'd1, utc_now + 6);
    send("R5", ME, 4'd2, utc_now + 5);
    send("R5", ME, 4'd2, utc_now + 4);
    idle("R5", 8);

    // R4: time base jumps over the requested instant
    send("R4", ME, 4'd9, utc_now + 20);
    idle("R4", 2);
    utc_now = utc_now + 50;
    idle("R4", 4);

    // R7 / R8: late message, dropped then fired
    late_fire_en = 1'b0;
    send("R7", ME, 4'd5, utc_now - 2);
    idle("R8", 3);
    late_fire_en = 1'b1;
    send("R8", ME, 4'd12, utc_now - 7);
    idle("R8", 3);
    late_fire_en = 1'b0;

    // R10: time equal to now at arrival
    send("R10", ME, 4'd14, utc_now);
    idle("R10", 4);

    // R11 / R9: fill the table, overflow, foreign while full, then fire all
    for (int k = 0; k < DEPTH; k++) send("R11", ME, ACT_W'(k), utc_now + 40 + 48'(k));
    send("R9", ME, 4'd15, utc_now + 10);
    send("R2", 8'h01, 4'd15, utc_now + 10);
    utc_now = utc_now + 100;
    idle("R5", 3);
    send("R11", ME, 4'd8, utc_now + 2);
    idle("R6", 5);

    // R9: overflow while an entry frees in the same cycle
    for (int k = 0; k < DEPTH - 1; k++) send("R11", ME, ACT_W'(k + 8), utc_now + 60);
    send("R11", ME, 4'd4, utc_now + 2);
    idle("R9", 1);
    send("R9", ME, 4'd10, utc_now + 30);
    send("R9", ME, 4'd11, utc_now + 30);
    utc_now = utc_now + 80;
    idle("R6", 4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule